// File: doc/BRIEF.md
# MMU Control and Interrupt Register Block

This block is the register front end of a small page-translating memory management unit. Software reaches it through a 32-bit register port: a byte address that must be word aligned, a write strobe, write data, and read data that always reflects the addressed register. The block holds the translation mode state: paging on or off, a requested stall, and an active page fault. It also holds the page-directory base address and the details of the captured fault. Writes to a command word move that state, and two kinds of TLB invalidation are sent to the translation logic as single-cycle pulses.

The translation datapath reports events on plain input pins. A fault strobe carries the faulting address, a write flag and the requester's bus id. A separate strobe reports a bus read error, and an idle level is also provided. A two-source interrupt controller collects these events. It has a raw register that software can also set, a write-one-to-clear register, an enable mask and a masked view. One interrupt line is driven whenever an enabled source is pending. The directory base can be written only while translation is halted, which means stalled, page-faulted or with paging off. A hard-reset command puts every register back to its power-on value.

Top module: `mmu_ctrl_regs`

## Requirements
- R1: After the asynchronous reset, every register reads zero except the status word. The status word reads 0x14 with the idle bit (bit 3) added when the idle input is high.
- R2: Registers sit at byte offsets 0x00 directory base, 0x04 status, 0x08 command, 0x0C fault address, 0x10 single-line invalidate, 0x14 raw interrupt, 0x18 interrupt clear, 0x1C interrupt mask and 0x20 masked interrupt. The command, invalidate and clear offsets read as zero. Offsets at or above 0x24, and addresses with nonzero low two bits, read zero and ignore writes.
- R3: Writing 0 to the command word turns paging on and writing 1 turns it off (status bit 0). Command values above 6 change nothing.
- R4: Command 2 requests a stall and command 3 drops it. A stall request made while a fault is active is dropped. Status bit 2 reads one when a stall is held or paging is off.
- R5: A write to the directory base takes effect only when status bit 2 or bit 1 is set in the cycle of the write. Otherwise the write is ignored.
- R6: A fault strobe that arrives with no fault active does the following: it stores the address at 0x0C and the write flag in status bit 5, puts the bus id in status bits 10:6, sets status bit 1, clears status bit 4 and sets raw interrupt bit 0. Fault strobes that arrive while a fault is active change none of these.
- R7: Command 5 clears the fault-active bit and sets status bit 4 again. It leaves the stored fault details and the raw interrupt bits unchanged.
- R8: Raw interrupt bit 0 is the page fault and bit 1 is the read bus error. A bus-error strobe sets bit 1. Writing ones to 0x14 sets those raw bits, and writing ones to 0x18 clears them, but a set in the same cycle wins over a clear. Offset 0x20 reads raw AND mask, and the interrupt line is high exactly when that value is nonzero.
- R9: Command 6 clears the directory base, paging, the stall request, the fault state and fault details, the raw bits and the mask. Any fault or bus-error strobe in that same cycle is discarded.
- R10: Command 4 raises the whole-cache invalidate output during the write cycle only. A write to 0x10 raises the line invalidate output for that cycle, with the written value on the line address output, which is zero otherwise.
- R11: Status bit 3 follows the idle input in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| flt_pulse | input | 1 | Translation fault event |
| flt_addr | input | 32 | Virtual address of the fault |
| flt_is_wr | input | 1 | Faulting access was a write |
| flt_bus_id | input | 5 | Requester id of the faulting access |
| berr_pulse | input | 1 | Bus read error event |
| idle_in | input | 1 | Translation logic is idle |
| irq | output | 1 | Interrupt request |
| inv_all_pulse | output | 1 | Invalidate the whole TLB |
| inv_line_pulse | output | 1 | Invalidate one TLB line |
| inv_line_addr | output | 32 | Value written for the line invalidate |

## Verification
The bench aims at the ordering corners. These include a second fault arriving while one is pending, which a design that re-latched would show as a changed fault address, and a stall request during a fault, which would show up as a set stall bit. They also include directory writes with translation running, which a design that did not guard them would accept. A bus-error strobe that coincides with a clear of the same bit is driven to catch a design that gives the clear priority, because that design would drop a pending interrupt. The bench issues hard reset while faults and interrupts are live, and it sends unknown command codes and misaligned or out-of-window writes, which a loose decoder would let change state.

// File: rtl/mmu_regs_pkg.sv
package mmu_regs_pkg;
  // word indices (byte offset / 4)
  localparam int unsigned WI_DIR   = 0;
  localparam int unsigned WI_STAT  = 1;
  localparam int unsigned WI_CMD   = 2;
  localparam int unsigned WI_FADDR = 3;
  localparam int unsigned WI_INVL  = 4;
  localparam int unsigned WI_RAW   = 5;
  localparam int unsigned WI_CLR   = 6;
  localparam int unsigned WI_MASK  = 7;
  localparam int unsigned WI_MSTAT = 8;
  localparam int unsigned N_WORDS  = 9;

  typedef enum logic [2:0] {
    C_PG_ON   = 3'd0,
    C_PG_OFF  = 3'd1,
    C_ST_ON   = 3'd2,
    C_ST_OFF  = 3'd3,
    C_INV_ALL = 3'd4,
    C_FLT_ACK = 3'd5,
    C_HRESET  = 3'd6
  } mmu_cmd_e;
  localparam int unsigned N_CMDS = 7;

  // status word bit positions
  localparam int unsigned SB_PAGING = 0;
  localparam int unsigned SB_FAULT  = 1;
  localparam int unsigned SB_STALL  = 2;
  localparam int unsigned SB_IDLE   = 3;
  localparam int unsigned SB_REPLAY = 4;
  localparam int unsigned SB_FWR    = 5;
  localparam int unsigned SB_ID_LO  = 6;
endpackage

// File: rtl/mmu_mode_ctrl.sv
module mmu_mode_ctrl #(
  parameter int DATA_W = 32,
  parameter int ID_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_pg_on,
  input  logic              cmd_pg_off,
  input  logic              cmd_st_on,
  input  logic              cmd_st_off,
  input  logic              cmd_ack,
  input  logic              cmd_hreset,
  input  logic              dir_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ev_flt,
  input  logic [DATA_W-1:0] ev_addr,
  input  logic              ev_wr,
  input  logic [ID_W-1:0]   ev_id,
  output logic              paging,
  output logic              stall_act,
  output logic              flt_act,
  output logic              flt_wr,
  output logic [ID_W-1:0]   flt_id,
  output logic [DATA_W-1:0] flt_addr,
  output logic [DATA_W-1:0] dir_base,
  output logic              flt_take
);
  logic pg_q, pg_d, st_q, st_d, fa_q, fa_d, fw_q, fw_d;
  logic [ID_W-1:0]   id_q, id_d;
  logic [DATA_W-1:0] ad_q, ad_d, dir_q, dir_d;
  logic halted;

  assign halted   = st_q | ~pg_q;
  assign flt_take = ev_flt & ~fa_q & ~cmd_hreset;

  always_comb begin
    pg_d = pg_q; st_d = st_q; fa_d = fa_q; fw_d = fw_q;
    id_d = id_q; ad_d = ad_q; dir_d = dir_q;
    if (cmd_hreset) begin
      pg_d = 1'b0; st_d = 1'b0; fa_d = 1'b0; fw_d = 1'b0;
      id_d = '0; ad_d = '0; dir_d = '0;
    end else begin
      if (cmd_pg_on)  pg_d = 1'b1;
      if (cmd_pg_off) pg_d = 1'b0;
      if (cmd_st_on && !fa_q) st_d = 1'b1;
      if (cmd_st_off) st_d = 1'b0;
      if (cmd_ack)    fa_d = 1'b0;
      if (flt_take) begin
        fa_d = 1'b1; fw_d = ev_wr; id_d = ev_id; ad_d = ev_addr;
      end
      if (dir_we && (halted || fa_q)) dir_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_q <= 1'b0; st_q <= 1'b0; fa_q <= 1'b0; fw_q <= 1'b0;
      id_q <= '0; ad_q <= '0; dir_q <= '0;
    end else begin
      pg_q <= pg_d; st_q <= st_d; fa_q <= fa_d; fw_q <= fw_d;
      id_q <= id_d; ad_q <= ad_d; dir_q <= dir_d;
    end
  end

  assign paging    = pg_q;
  assign stall_act = halted;
  assign flt_act   = fa_q;
  assign flt_wr    = fw_q;
  assign flt_id    = id_q;
  assign flt_addr  = ad_q;
  assign dir_base  = dir_q;

  assert_dir_guard_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && !fa_q && !cmd_hreset) |=> $stable(dir_q));
  assert_fault_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fa_q && !cmd_ack && !cmd_hreset) |=> (fa_q && $stable(ad_q) && $stable(id_q)));
  assert_stall_refuse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fa_q && !st_q) |=> !st_q);
  assert_hreset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_hreset |=> (!pg_q && !st_q && !fa_q && dir_q == '0));
endmodule

// File: rtl/mmu_irq_ctrl.sv
module mmu_irq_ctrl #(
  parameter int IRQ_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_all,
  input  logic [IRQ_N-1:0] src_set,
  input  logic             raw_we,
  input  logic             clr_we,
  input  logic             mask_we,
  input  logic [IRQ_N-1:0] wbits,
  output logic [IRQ_N-1:0] raw,
  output logic [IRQ_N-1:0] mask,
  output logic [IRQ_N-1:0] masked
);
  logic [IRQ_N-1:0] raw_q, raw_d, mask_q, mask_d;

  for (genvar i = 0; i < IRQ_N; i++) begin : g_src
    logic set_i, clr_i;
    assign set_i = src_set[i] | (raw_we & wbits[i]);
    assign clr_i = clr_we & wbits[i];
    always_comb begin
      raw_d[i]  = clear_all ? 1'b0 : (set_i | (raw_q[i] & ~clr_i));
      mask_d[i] = clear_all ? 1'b0 : (mask_we ? wbits[i] : mask_q[i]);
    end

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && wbits[i] && !src_set[i] && !raw_we) |=> !raw_q[i]);
    assert_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (src_set[i] && !clear_all) |=> raw_q[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q  <= raw_d;
      mask_q <= mask_d;
    end
  end

  assign raw    = raw_q;
  assign mask   = mask_q;
  assign masked = raw_q & mask_q;
endmodule

// File: rtl/mmu_ctrl_regs.sv
module mmu_ctrl_regs
  import mmu_regs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int ID_W   = 5,
  parameter int IRQ_N  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              flt_pulse,
  input  logic [DATA_W-1:0] flt_addr,
  input  logic              flt_is_wr,
  input  logic [ID_W-1:0]   flt_bus_id,
  input  logic              berr_pulse,
  input  logic              idle_in,
  output logic              irq,
  output logic              inv_all_pulse,
  output logic              inv_line_pulse,
  output logic [DATA_W-1:0] inv_line_addr
);
  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] widx;
  logic              aligned;
  logic [N_WORDS-1:0] sel;
  logic [N_CMDS-1:0]  cmd_hit;

  assign widx    = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);

  for (genvar k = 0; k < N_WORDS; k++) begin : g_sel
    assign sel[k] = aligned && (widx == WIDX_W'(k));
  end
  for (genvar c = 0; c < N_CMDS; c++) begin : g_cmd
    assign cmd_hit[c] = bus_wr && sel[WI_CMD] && (bus_wdata == DATA_W'(c));
  end

  logic              pg, st_act, fa, fw, take;
  logic [ID_W-1:0]   fid;
  logic [DATA_W-1:0] fad, dir;
  logic [IRQ_N-1:0]  raw, mask, masked, src;

  mmu_mode_ctrl #(.DATA_W(DATA_W), .ID_W(ID_W)) u_mode (
    .clk(clk), .rst_n(rst_n),
    .cmd_pg_on(cmd_hit[C_PG_ON]), .cmd_pg_off(cmd_hit[C_PG_OFF]),
    .cmd_st_on(cmd_hit[C_ST_ON]), .cmd_st_off(cmd_hit[C_ST_OFF]),
    .cmd_ack(cmd_hit[C_FLT_ACK]), .cmd_hreset(cmd_hit[C_HRESET]),
    .dir_we(bus_wr && sel[WI_DIR]), .wdata(bus_wdata),
    .ev_flt(flt_pulse), .ev_addr(flt_addr), .ev_wr(flt_is_wr), .ev_id(flt_bus_id),
    .paging(pg), .stall_act(st_act), .flt_act(fa), .flt_wr(fw), .flt_id(fid),
    .flt_addr(fad), .dir_base(dir), .flt_take(take)
  );

  always_comb begin
    src    = '0;
    src[0] = take;
    src[1] = berr_pulse;
  end

  mmu_irq_ctrl #(.IRQ_N(IRQ_N)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .clear_all(cmd_hit[C_HRESET]), .src_set(src),
    .raw_we(bus_wr && sel[WI_RAW]), .clr_we(bus_wr && sel[WI_CLR]),
    .mask_we(bus_wr && sel[WI_MASK]), .wbits(bus_wdata[IRQ_N-1:0]),
    .raw(raw), .mask(mask), .masked(masked)
  );

  logic [DATA_W-1:0] status;
  always_comb begin
    status = '0;
    status[SB_PAGING] = pg;
    status[SB_FAULT]  = fa;
    status[SB_STALL]  = st_act;
    status[SB_IDLE]   = idle_in;
    status[SB_REPLAY] = ~fa;
    status[SB_FWR]    = fw;
    status[SB_ID_LO +: ID_W] = fid;
  end

  always_comb begin
    bus_rdata = '0;
    if (sel[WI_DIR])        bus_rdata = dir;
    else if (sel[WI_STAT])  bus_rdata = status;
    else if (sel[WI_FADDR]) bus_rdata = fad;
    else if (sel[WI_RAW])   bus_rdata = DATA_W'(raw);
    else if (sel[WI_MASK])  bus_rdata = DATA_W'(mask);
    else if (sel[WI_MSTAT]) bus_rdata = DATA_W'(masked);
  end

  assign irq            = |masked;
  assign inv_all_pulse  = cmd_hit[C_INV_ALL];
  assign inv_line_pulse = bus_wr && sel[WI_INVL];
  assign inv_line_addr  = inv_line_pulse ? bus_wdata : '0;

  assert_irq_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);
  assert_inv_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all_pulse |=> (!inv_all_pulse || $past(bus_wr)));
endmodule

// File: tb/sim_mmu_ctrl_regs.sv
`timescale 1ns/1ps
module sim_mmu_ctrl_regs;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        flt_pulse, flt_is_wr, berr_pulse, idle_in;
  logic [31:0] flt_addr;
  logic [4:0]  flt_bus_id;
  logic        irq, inv_all_pulse, inv_line_pulse;
  logic [31:0] inv_line_addr;

  int nchk = 0;
  int nerr = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  mmu_ctrl_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .flt_pulse(flt_pulse),
    .flt_addr(flt_addr), .flt_is_wr(flt_is_wr), .flt_bus_id(flt_bus_id),
    .berr_pulse(berr_pulse), .idle_in(idle_in), .irq(irq),
    .inv_all_pulse(inv_all_pulse), .inv_line_pulse(inv_line_pulse),
    .inv_line_addr(inv_line_addr)
  );

  // behavioural reference state
  logic        m_pg, m_st, m_flt, m_fw;
  logic [4:0]  m_id;
  logic [31:0] m_fa, m_dir;
  logic [1:0]  m_mask, m_raw;

  function automatic bit is_word(input logic [7:0] a, input int w);
    return (a[1:0] == 2'b00) && (int'(a >> 2) == w);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pg = 0; m_st = 0; m_flt = 0; m_fw = 0; m_id = 0;
      m_fa = 0; m_dir = 0; m_mask = 0; m_raw = 0;
    end else if (bus_wr && is_word(bus_addr, 2) && bus_wdata == 6) begin
      m_pg = 0; m_st = 0; m_flt = 0; m_fw = 0; m_id = 0;
      m_fa = 0; m_dir = 0; m_mask = 0; m_raw = 0;
    end else begin
      automatic bit halted = m_st || !m_pg;
      automatic bit pre_flt = m_flt;
      automatic logic [1:0] setb = {berr_pulse, flt_pulse && !pre_flt};
      automatic logic [1:0] clrb = 0;
      if (bus_wr && is_word(bus_addr, 2)) begin
        case (bus_wdata)
          0: m_pg = 1;
          1: m_pg = 0;
          2: if (!pre_flt) m_st = 1;
          3: m_st = 0;
          5: m_flt = 0;
          default: ;
        endcase
      end
      if (flt_pulse && !pre_flt) begin
        m_flt = 1; m_fw = flt_is_wr; m_id = flt_bus_id; m_fa = flt_addr;
      end
      if (bus_wr && is_word(bus_addr, 0) && (halted || pre_flt)) m_dir = bus_wdata;
      if (bus_wr && is_word(bus_addr, 7)) m_mask = bus_wdata[1:0];
      if (bus_wr && is_word(bus_addr, 5)) setb = setb | bus_wdata[1:0];
      if (bus_wr && is_word(bus_addr, 6)) clrb = bus_wdata[1:0];
      m_raw = (m_raw & ~clrb) | setb;
    end
  end

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    logic [31:0] s;
    s = {21'b0, m_id, m_fw, !m_flt, idle_in, (m_st || !m_pg), m_flt, m_pg};
    if (a[1:0] != 0) return 0;
    case (int'(a >> 2))
      0: return m_dir;
      1: return s;
      3: return m_fa;
      5: return {30'b0, m_raw};
      7: return {30'b0, m_mask};
      8: return {30'b0, m_raw & m_mask};
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    if (a[1:0] != 0) return "R2";
    case (int'(a >> 2))
      0: return "R5";
      1: return "R4";
      3: return "R6";
      5, 7, 8: return "R8";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // compare against the model every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !finished) begin
      #1;
      chk(tag_of(bus_addr), bus_rdata, exp_read(bus_addr));
      chk("R8 irq", {31'b0, irq}, {31'b0, (m_raw & m_mask) != 0});
      chk("R10 inv_all", {31'b0, inv_all_pulse},
          {31'b0, bus_wr && is_word(bus_addr, 2) && bus_wdata == 4});
      chk("R10 inv_line", {31'b0, inv_line_pulse}, {31'b0, bus_wr && is_word(bus_addr, 4)});
      chk("R10 inv_addr", inv_line_addr,
          (bus_wr && is_word(bus_addr, 4)) ? bus_wdata : 32'h0);
    end
  end

  task automatic op(input logic wr, input logic [7:0] a, input logic [31:0] d,
                    input logic fp, input logic be);
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d; flt_pulse = fp; berr_pulse = be;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    op(0, a, 0, 0, 0);
    #1 chk(tag, bus_rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nerr++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    rst_n = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0; flt_pulse = 0;
    berr_pulse = 0; idle_in = 1; flt_addr = 0; flt_is_wr = 0; flt_bus_id = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    rd(8'h04, 32'h1C, "R1 status");
    rd(8'h00, 32'h0, "R1 dir");
    rd(8'h1C, 32'h0, "R1 mask");
    rd(8'h14, 32'h0, "R1 raw");

    op(1, 8'h00, 32'h1000, 0, 0);           // paging off -> halted
    rd(8'h00, 32'h1000, "R5 dir written while paging off");
    op(1, 8'h08, 32'd0, 0, 0);
    rd(8'h04, 32'h19, "R3 paging on");
    op(1, 8'h00, 32'h2000, 0, 0);
    rd(8'h00, 32'h1000, "R5 dir ignored while running");
    op(1, 8'h08, 32'd2, 0, 0);
    rd(8'h04, 32'h1D, "R4 stall held");
    op(1, 8'h00, 32'h3000, 0, 0);
    rd(8'h00, 32'h3000, "R5 dir written while stalled");
    op(1, 8'h08, 32'd3, 0, 0);
    rd(8'h04, 32'h19, "R4 stall dropped");

    flt_addr = 32'hDEAD0000; flt_is_wr = 1; flt_bus_id = 5'h13;
    op(0, 8'h04, 0, 1, 0);
    rd(8'h0C, 32'hDEAD0000, "R6 fault address");
    rd(8'h04, 32'h4EB, "R6 fault status");
    rd(8'h14, 32'h1, "R6 raw fault bit");
    flt_addr = 32'h12340000; flt_is_wr = 0; flt_bus_id = 5'h01;
    op(0, 8'h04, 0, 1, 0);
    rd(8'h0C, 32'hDEAD0000, "R6 second fault ignored");
    op(1, 8'h08, 32'd2, 0, 0);
    rd(8'h04, 32'h4EB, "R4 stall refused during fault");
    op(1, 8'h00, 32'h4000, 0, 0);
    rd(8'h00, 32'h4000, "R5 dir written during fault");

    op(1, 8'h1C, 32'h3, 0, 0);
    rd(8'h20, 32'h1, "R8 masked status");
    chk("R8 irq high", {31'b0, irq}, 32'h1);
    op(0, 8'h04, 0, 0, 1);
    rd(8'h14, 32'h3, "R8 bus error bit");
    op(1, 8'h18, 32'h2, 0, 0);
    rd(8'h14, 32'h1, "R8 clear bit1");
    op(1, 8'h14, 32'h2, 0, 0);
    rd(8'h14, 32'h3, "R8 software inject");
    op(1, 8'h18, 32'h2, 0, 1);
    rd(8'h14, 32'h3, "R8 set beats clear");
    op(1, 8'h08, 32'd5, 0, 0);
    rd(8'h04, 32'h4F9, "R7 fault done status");
    rd(8'h14, 32'h3, "R7 raw kept");
    op(1, 8'h18, 32'h3, 0, 0);
    rd(8'h20, 32'h0, "R8 all cleared");
    chk("R8 irq low", {31'b0, irq}, 32'h0);

    op(1, 8'h08, 32'd4, 0, 0);
    #1 chk("R10 inv_all pulse", {31'b0, inv_all_pulse}, 32'h1);
    op(1, 8'h10, 32'hABC0, 0, 0);
    #1 chk("R10 inv_line addr", inv_line_addr, 32'hABC0);
    op(0, 8'h10, 32'hABC0, 0, 0);
    #1 chk("R10 pulse ends", {31'b0, inv_line_pulse}, 32'h0);

    op(1, 8'h08, 32'd7, 0, 0);
    rd(8'h04, 32'h4F9, "R3 unknown code ignored");
    op(1, 8'h24, 32'hFF, 0, 0);
    rd(8'h24, 32'h0, "R2 out of window");
    op(1, 8'h1D, 32'h0, 0, 0);
    rd(8'h1C, 32'h3, "R2 misaligned write ignored");
    idle_in = 0;
    rd(8'h04, 32'h4F1, "R11 idle low");

    op(0, 8'h04, 0, 1, 0);
    op(0, 8'h04, 0, 0, 0);
    op(1, 8'h08, 32'd6, 1, 1);
    rd(8'h04, 32'h14, "R9 status after hard reset");
    rd(8'h00, 32'h0, "R9 dir");
    rd(8'h0C, 32'h0, "R9 fault address");
    rd(8'h14, 32'h0, "R9 raw");
    rd(8'h1C, 32'h0, "R9 mask");

    for (int i = 0; i < 4000; i++) begin
      automatic logic [7:0] a = 8'($urandom_range(0, 10) * 4);
      automatic logic [31:0] d = $urandom;
      if (a == 8'h08) d = $urandom_range(0, 7);
      else if (a != 8'h00 && a != 8'h10) d = d & 32'h3;
      if ($urandom_range(0, 40) == 0) a = a | 8'h1;
      flt_addr = $urandom; flt_is_wr = 1'($urandom); flt_bus_id = 5'($urandom);
      idle_in = 1'($urandom);
      op(1'($urandom), a, d, ($urandom_range(0, 9) == 0), ($urandom_range(0, 9) == 0));
    end
    op(0, 8'h04, 0, 0, 0);
    @(negedge clk);
    #2;
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule